// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block owns the program counter of a 32-bit processor whose instructions are one word each and whose memory is addressed by word. Each cycle it may accept one decoded control-flow operation, together with the value read from the register named in the instruction's first register field and the instruction's 22-bit address field. From these it works out where execution goes next. That can be the following word, an absolute target, or an address held in a register. A call also returns a write to the register file that records where execution resumes, and a stop request freezes the counter.

Operations arrive on a valid/ready handshake. An operation is taken on a rising edge only when `op_valid` and `op_ready` are both high. While `op_valid` is low the counter holds. The unit applies back-pressure only after a stop: `op_ready` stays low from the cycle after the stop until reset, and any operation offered in that time is left untaken. The link write comes out as plain combinational outputs in the cycle of acceptance, so the register file can commit it on the same edge that updates the counter.

Top module: `npc_unit`

## Requirements
- R1: With `rst` high at a rising edge, `pc` becomes the parameter RESET_PC and `halted` becomes 0. After reset is released, `op_ready` is 1.
- R2: Operation codes on `op_kind` are 0 none, 1 jmp, 2 jt, 3 jf, 4 jal, 5 ret, 6 trap, and code 7 behaves like none. An accepted none advances `pc` by 1. A cycle with `op_valid` low leaves `pc` unchanged.
- R3: An accepted jmp loads `pc` with `addr_field` sign-extended from bit 21 to the full address width.
- R4: An accepted jt loads the sign-extended target when `r1_val` is nonzero, and otherwise advances `pc` by 1.
- R5: An accepted jf loads the sign-extended target when `r1_val` is zero, and otherwise advances `pc` by 1.
- R6: An accepted jal loads the sign-extended target. In the same cycle it raises `link_we` with `link_idx` equal to `r1_idx` and `link_data` equal to `pc`+1. When `r1_idx` is 0, `link_we` stays low and the jump still happens. `link_we` is never high unless an operation is being accepted.
- R7: An accepted ret loads `pc` with `r1_val`.
- R8: An accepted trap with `r1_idx` equal to 0 leaves `pc` unchanged and sets `halted` at the next edge. From then until reset, `op_ready` is 0, `pc` does not change, and offered operations have no effect. A trap with any other number acts like none.
- R9: `next_pc` always shows the value `pc` will take at the next rising edge when `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The unit can take an operation (low once halted) |
| op_kind | input | 3 | Control-flow operation code |
| r1_idx | input | 5 | First register field: link target or trap number |
| r1_val | input | 32 | Value of the register named by the first field |
| addr_field | input | 22 | Raw address field, sign-extended inside |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Counter value after the coming edge |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Return address written on a call |
| halted | output | 1 | Execution stopped by trap 0 |

## Verification
The bench builds the unit with a 32-bit address, a 22-bit field, 5-bit register indices and RESET_PC set to 16. The nonzero reset value makes it visible if the counter ever falls back to zero, or if reset fails to restore it. With the 22-bit field inside a 32-bit address, a field whose top bit is set sends the counter into the upper end of the address space, so sign extension is tested directly. This shape also lets a return go to a full 32-bit register value that no address field could encode.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    CF_NONE = 3'd0,
    CF_JMP  = 3'd1,
    CF_JT   = 3'd2,
    CF_JF   = 3'd3,
    CF_JAL  = 3'd4,
    CF_RET  = 3'd5,
    CF_TRAP = 3'd6,
    CF_RSVD = 3'd7
  } cf_op_e;
endpackage

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 22,
  parameter int IDX_W   = 5
) (
  input  cf_op_e            op,
  input  logic [IDX_W-1:0]  r1_idx,
  input  logic [ADDR_W-1:0] r1_val,
  input  logic [ADDR_W-1:0] pc,
  input  logic [FIELD_W-1:0] field,
  output logic [ADDR_W-1:0] target,
  output logic              halt_req
);
  logic [ADDR_W-1:0] ext;
  logic [ADDR_W-1:0] seq;
  logic              reg_zero;

  generate
    if (FIELD_W < ADDR_W) begin : g_ext
      assign ext = {{(ADDR_W-FIELD_W){field[FIELD_W-1]}}, field};
    end else begin : g_trunc
      assign ext = field[ADDR_W-1:0];
    end
  endgenerate

  assign seq      = pc + ADDR_W'(1);
  assign reg_zero = (r1_val == '0);

  always_comb begin
    target   = seq;
    halt_req = 1'b0;
    unique case (op)
      CF_JMP:  target = ext;
      CF_JT:   target = reg_zero ? seq : ext;
      CF_JF:   target = reg_zero ? ext : seq;
      CF_JAL:  target = ext;
      CF_RET:  target = r1_val;
      CF_TRAP: begin
        if (r1_idx == '0) begin
          target   = pc;
          halt_req = 1'b1;
        end
      end
      default: target = seq;
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              fire,
  input  cf_op_e            op,
  input  logic [IDX_W-1:0]  r1_idx,
  input  logic [ADDR_W-1:0] pc,
  output logic              we,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] data
);
  assign we   = fire && (op == CF_JAL) && (r1_idx != '0);
  assign idx  = r1_idx;
  assign data = pc + ADDR_W'(1);
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              halt_req,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc,
  output logic              halted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_PC;
      halted <= 1'b0;
    end else if (fire) begin
      pc <= target;
      if (halt_req) halted <= 1'b1;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(pc));
  p_follow_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> pc == $past(target));
  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && halt_req) |=> halted);
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc)));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 22,
  parameter int IDX_W   = 5,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_kind,
  input  logic [IDX_W-1:0]  r1_idx,
  input  logic [ADDR_W-1:0] r1_val,
  input  logic [FIELD_W-1:0] addr_field,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              link_we,
  output logic [IDX_W-1:0]  link_idx,
  output logic [ADDR_W-1:0] link_data,
  output logic              halted
);
  cf_op_e            op;
  logic              fire;
  logic              halt_req;
  logic [ADDR_W-1:0] target;

  assign op       = cf_op_e'(op_kind);
  assign op_ready = !halted;
  assign fire     = op_valid && op_ready;
  assign next_pc  = fire ? target : pc;

  npc_target #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_target (
    .op(op), .r1_idx(r1_idx), .r1_val(r1_val), .pc(pc),
    .field(addr_field), .target(target), .halt_req(halt_req)
  );

  npc_link #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_link (
    .fire(fire), .op(op), .r1_idx(r1_idx), .pc(pc),
    .we(link_we), .idx(link_idx), .data(link_data)
  );

  npc_pcreg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pcreg (
    .clk(clk), .rst(rst), .fire(fire), .halt_req(halt_req),
    .target(target), .pc(pc), .halted(halted)
  );

  p_link_accept_r6: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (op_valid && op_ready));
  p_ret_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && op == CF_RET) |=> pc == $past(r1_val));
endmodule

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  localparam logic [31:0] RPC = 32'd16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_kind = 3'd0;
  logic [4:0]  r1_idx = 5'd0;
  logic [31:0] r1_val = 32'd0;
  logic [21:0] addr_field = 22'd0;
  logic [31:0] pc, next_pc, link_data;
  logic        link_we, halted;
  logic [4:0]  link_idx;

  always #2 clk = ~clk;

  npc_unit #(.ADDR_W(32), .FIELD_W(22), .IDX_W(5), .RESET_PC(RPC)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .r1_idx(r1_idx), .r1_val(r1_val), .addr_field(addr_field),
    .pc(pc), .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx),
    .link_data(link_data), .halted(halted)
  );

  typedef struct {
    logic [31:0] pc;
    logic        halted;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] m_pc = RPC;
  logic        m_halted = 1'b0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected state one step after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(pc == e.pc, {e.tag, " pc"}, pc, e.pc);
        check(halted == e.halted, {e.tag, " halted"}, 32'(halted), 32'(e.halted));
      end
    end
  end

  task automatic issue(input bit v, input logic [2:0] k, input logic [4:0] idx,
                       input logic [31:0] rv, input logic [21:0] f, input string tag);
    logic [31:0] ext, nx;
    logic        nh, acc, exp_we;
    exp_t        e;
    @(negedge clk);
    op_valid = v; op_kind = k; r1_idx = idx; r1_val = rv; addr_field = f;
    #1;
    ext = {{10{f[21]}}, f};
    acc = v && !m_halted;
    nx = m_pc; nh = m_halted;
    if (acc) begin
      case (k)
        3'd1: nx = ext;
        3'd2: nx = (rv != 0) ? ext : m_pc + 1;
        3'd3: nx = (rv == 0) ? ext : m_pc + 1;
        3'd4: nx = ext;
        3'd5: nx = rv;
        3'd6: if (idx == 0) nh = 1'b1; else nx = m_pc + 1;
        default: nx = m_pc + 1;
      endcase
    end
    check(op_ready == !m_halted, {tag, " ready R8"}, 32'(op_ready), 32'(!m_halted));
    exp_we = acc && k == 3'd4 && idx != 0;
    check(link_we == exp_we, {tag, " link_we R6"}, 32'(link_we), 32'(exp_we));
    if (exp_we) begin
      check(link_idx == idx, {tag, " link_idx R6"}, 32'(link_idx), 32'(idx));
      check(link_data == m_pc + 1, {tag, " link_data R6"}, link_data, m_pc + 1);
    end
    check(next_pc == nx, {tag, " next_pc R9"}, next_pc, nx);
    m_pc = nx; m_halted = nh;
    e.pc = nx; e.halted = nh; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic reset_check();
    @(negedge clk);
    op_valid = 1'b0; rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = RPC; m_halted = 1'b0;
    #1;
    check(pc == RPC, "R1 pc", pc, RPC);
    check(halted == 1'b0, "R1 halted", 32'(halted), 0);
    check(op_ready == 1'b1, "R1 ready", 32'(op_ready), 1);
  endtask

  initial begin
    reset_check();
    issue(1, 3'd0, 5'd0, 32'd0, 22'd0, "R2 none");
    issue(1, 3'd0, 5'd3, 32'd9, 22'd5, "R2 none2");
    issue(0, 3'd1, 5'd0, 32'd0, 22'h100, "R2 idle");
    issue(1, 3'd7, 5'd0, 32'd0, 22'h100, "R2 code7");
    issue(1, 3'd1, 5'd0, 32'd0, 22'h1234, "R3 jmp pos");
    issue(1, 3'd1, 5'd0, 32'd0, 22'h3FFFF0, "R3 jmp neg");
    issue(1, 3'd1, 5'd0, 32'd0, 22'h1FFFFF, "R3 jmp max");
    issue(1, 3'd2, 5'd4, 32'd0, 22'h200, "R4 jt zero");
    issue(1, 3'd2, 5'd4, 32'h80000000, 22'h200, "R4 jt set");
    issue(1, 3'd3, 5'd4, 32'd1, 22'h300, "R5 jf set");
    issue(1, 3'd3, 5'd4, 32'd0, 22'h300, "R5 jf zero");
    issue(1, 3'd4, 5'd31, 32'd0, 22'h400, "R6 jal r31");
    issue(1, 3'd4, 5'd0, 32'd0, 22'h2AAAAA, "R6 jal r0");
    issue(1, 3'd5, 5'd31, 32'hDEADBEEF, 22'd0, "R7 ret");
    issue(1, 3'd6, 5'd3, 32'd0, 22'd0, "R8 trap3");
    issue(1, 3'd6, 5'd0, 32'd0, 22'd0, "R8 trap0");
    issue(1, 3'd1, 5'd0, 32'd0, 22'h55, "R8 jmp halted");
    issue(1, 3'd4, 5'd7, 32'd0, 22'h66, "R8 jal halted");
    issue(0, 3'd0, 5'd0, 32'd0, 22'd0, "R8 idle halted");
    @(posedge clk); #1;
    reset_check();
    issue(1, 3'd0, 5'd0, 32'd0, 22'd0, "R1 after reset");
    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule